// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Whole-Character Break and Idle Queuing

This block is the sending half of an asynchronous serial port. Software-style writes put a character into a single holding register. From there the character moves into a shift register, which sends it out on the serial line as a start bit, 8 or 9 data bits (least significant first) and a stop bit. Each bit lasts a fixed number of pulses of an externally generated bit-rate tick. The caller can see when the holding register can take a new character and when the whole transmitter has gone quiet.

Two special characters can be requested besides normal data. A break is a full frame of zeros. It is requested by raising a break control, and it keeps repeating as whole frames for as long as that control stays high. An idle character is a full frame of ones. It is requested by turning the transmit enable off and on again. Both kinds are queued behind whatever frame is on the line and are never cut short. When several requests wait together, break goes first, then idle, then buffered data.

Top module: `sertx_top`

## Requirements
- R1: During and right after reset the serial line is high (1), the data-empty status is 1 and the transmit-complete status is 1.
- R2: A data frame is a 0 start bit, then the data bits least significant first (8 bits when the frame-size input is 0, 9 bits when it is 1, as sampled when the frame is loaded), then a 1 stop bit. Each bit is held for 16 bit-rate ticks.
- R3: A data write sets data-empty to 0 at the next clock. Data-empty returns to 1 in the clock in which the character moves into the shift register.
- R4: A break frame holds the line at 0 for 10 bit times with the frame-size input at 0, and for 11 bit times with it at 1.
- R5: A rising edge of the break control queues at least one break frame, even if the control falls again in the next cycle.
- R6: A queued break, idle or data frame waits until the frame on the line has sent its last bit. It then starts in that same clock, with no gap cycle.
- R7: While the break control is still high when a break frame is loaded, one more break frame is queued. Data resumes only after the last break frame is finished.
- R8: A 0-to-1 transition of the transmit enable queues an idle frame: the line stays at 1 for 10 or 11 bit times, matching the frame size.
- R9: Among waiting requests, break is loaded before idle and idle before data. Data written after an idle request starts only after the idle frame.
- R10: Transmit-complete is 1 exactly when no frame is shifting and no data, idle or break request is pending.
- R11: Frames are loaded only when the transmit enable has been 1 for the current and the previous clock. Clearing the enable never stops a frame that is already on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmit enable; a 0-to-1 transition queues an idle frame |
| sendBreak | input | 1 | Break control; a rising edge queues a break, and holding it high repeats it |
| nineBit | input | 1 | Frame size: 0 gives 8 data bits, 1 gives 9 data bits |
| dataWrite | input | 1 | Write strobe for the holding register |
| dataIn | input | 9 | Character to write; bit 8 is used only in 9-bit frames |
| bitTick | input | 1 | Bit-rate tick, 16 per bit time |
| dataEmpty | output | 1 | Holding register can take a new character |
| txDone | output | 1 | Transmitter fully quiet, with nothing pending |
| txLine | output | 1 | Serial output, high when idle |

## Verification
The bench aims at the hand-over points between frames. These are:
- a break pulsed for one cycle in the middle of a data frame, which a wrong design would drop or use to chop the data frame;
- a break held across a frame boundary, where a design that miscounts repeats would give one break too few or too many, which shows up as a wrong length of the zero run on the line;
- an enable toggle with data already buffered, where a design that gets the priority wrong would send the data ahead of the idle frame.

Outputs are also checked while the enable is off, and across a change of frame size. A design that loads while disabled, or that leaves a one-cycle high gap between back-to-back frames, differs from the bench's cycle-level model at once.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // Strobes and state handed from control to datapath each cycle
  typedef struct packed {
    logic loadData;   // move holding register into shifter as a data frame
    logic loadIdle;   // load an all-ones frame
    logic loadBreak;  // load an all-zeros frame
    logic shiftBit;   // advance shifter by one bit
    logic longFrame;  // 9 data bits in the frame being loaded
    logic lineOn;     // shifter is driving the line
  } txStrobes_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_MAX     = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       sendBreak,
  input  logic       nineBit,
  input  logic       dataWrite,
  input  logic       bitTick,
  output txStrobes_t strb,
  output logic       dataEmpty,
  output logic       txDone
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BW = $clog2(FRAME_MAX);
  localparam logic [TW-1:0] TICK_LAST  = TW'(TICKS_PER_BIT - 1);
  localparam logic [BW-1:0] LONG_LAST  = BW'(FRAME_MAX - 1);
  localparam logic [BW-1:0] SHORT_LAST = BW'(FRAME_MAX - 2);

  logic          enPrev, brkPrev;
  logic          idlePend, breakPend, holdFull;
  logic          active;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitCnt, lastIdx;

  logic enRise, brkRise, shiftBit, lastShift, slotFree, canLoad;
  logic loadData, loadIdle, loadBreak, anyLoad;

  always_comb begin
    enRise    = txEnable && !enPrev;
    brkRise   = sendBreak && !brkPrev;
    shiftBit  = active && bitTick && (tickCnt == TICK_LAST);
    lastShift = shiftBit && (bitCnt == lastIdx);
    slotFree  = !active || lastShift;
    canLoad   = txEnable && enPrev && slotFree;
    loadBreak = canLoad && breakPend;
    loadIdle  = canLoad && !breakPend && idlePend;
    loadData  = canLoad && !breakPend && !idlePend && holdFull;
    anyLoad   = loadBreak || loadIdle || loadData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev    <= 1'b0;
      brkPrev   <= 1'b0;
      idlePend  <= 1'b0;
      breakPend <= 1'b0;
      holdFull  <= 1'b0;
    end else begin
      enPrev  <= txEnable;
      brkPrev <= sendBreak;
      if (enRise)        idlePend <= 1'b1;
      else if (loadIdle) idlePend <= 1'b0;
      if (brkRise)        breakPend <= 1'b1;
      else if (loadBreak) breakPend <= sendBreak;
      if (dataWrite)     holdFull <= 1'b1;
      else if (loadData) holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      tickCnt <= '0;
      bitCnt  <= '0;
      lastIdx <= SHORT_LAST;
    end else if (anyLoad) begin
      active  <= 1'b1;
      tickCnt <= '0;
      bitCnt  <= '0;
      lastIdx <= nineBit ? LONG_LAST : SHORT_LAST;
    end else if (active && bitTick) begin
      tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
      if (shiftBit) begin
        bitCnt <= bitCnt + 1'b1;
        if (lastShift) active <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.loadData  = loadData;
    strb.loadIdle  = loadIdle;
    strb.loadBreak = loadBreak;
    strb.shiftBit  = shiftBit;
    strb.longFrame = nineBit;
    strb.lineOn    = active;
    dataEmpty      = !holdFull;
    txDone         = !active && !holdFull && !idlePend && !breakPend;
  end

  // R3
  write_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> !dataEmpty);
  // R10
  done_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> dataEmpty);
  // R9
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadData, loadIdle, loadBreak}));
  // R7
  break_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadBreak && sendBreak) |=> !txDone);
  // R6
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(breakPend || idlePend || holdFull));
  // R11
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !$rose(active));
endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int FRAME_MAX = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataWrite,
  input  logic [DATA_W-1:0] dataIn,
  input  txStrobes_t        strb,
  output logic              txLine
);
  logic [DATA_W-1:0]    holdReg;
  logic [FRAME_MAX-1:0] shReg, dataFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdReg <= '0;
    else if (dataWrite) holdReg <= dataIn;
  end

  // start bit at position 0, stop/filler ones above the data
  always_comb begin
    dataFrame    = '1;
    dataFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < DATA_W - 1 || strb.longFrame) dataFrame[i+1] = holdReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shReg <= '1;
    else if (strb.loadBreak) shReg <= '0;
    else if (strb.loadIdle)  shReg <= '1;
    else if (strb.loadData)  shReg <= dataFrame;
    else if (strb.shiftBit)  shReg <= {1'b1, shReg[FRAME_MAX-1:1]};
  end

  assign txLine = strb.lineOn ? shReg[0] : 1'b1;

  // R4
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBreak |=> !txLine);
  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIdle |=> txLine);
  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |=> !txLine);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 9,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              sendBreak,
  input  logic              nineBit,
  input  logic              dataWrite,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bitTick,
  output logic              dataEmpty,
  output logic              txDone,
  output logic              txLine
);
  localparam int FRAME_MAX = DATA_W + 2;

  txStrobes_t strb;

  sertx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .FRAME_MAX(FRAME_MAX)) ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .sendBreak(sendBreak),
    .nineBit(nineBit), .dataWrite(dataWrite), .bitTick(bitTick),
    .strb(strb), .dataEmpty(dataEmpty), .txDone(txDone));

  sertx_dp #(.DATA_W(DATA_W), .FRAME_MAX(FRAME_MAX)) dp (
    .clk(clk), .rstN(rstN), .dataWrite(dataWrite), .dataIn(dataIn),
    .strb(strb), .txLine(txLine));
endmodule

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;
  logic clk = 0, rstN = 0;
  logic txEnable = 0, sendBreak = 0, nineBit = 0, dataWrite = 0, bitTick = 0;
  logic [8:0] dataIn = '0;
  logic dataEmpty, txDone, txLine;
  int nChecks = 0, nFails = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sertx_top uut (.clk(clk), .rstN(rstN), .txEnable(txEnable), .sendBreak(sendBreak),
    .nineBit(nineBit), .dataWrite(dataWrite), .dataIn(dataIn), .bitTick(bitTick),
    .dataEmpty(dataEmpty), .txDone(txDone), .txLine(txLine));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // bit-rate tick every other clock
  always @(negedge clk) bitTick <= ~bitTick;

  // ---------------- behavioural reference model ----------------
  bit mBits[$];
  int mTick, mKind;            // 0 data, 1 idle, 2 break
  bit mActive, mHoldFull, mIdle, mBrk, mEnPrev, mBrkPrev;
  bit [8:0] mHold;
  int lowCnt, lastLow;

  always @(posedge clk) begin
    if (!rstN) begin
      mBits.delete(); mTick = 0; mKind = 0; mActive = 0; mHoldFull = 0;
      mIdle = 0; mBrk = 0; mEnPrev = 0; mBrkPrev = 0; mHold = 0;
      lowCnt = 0; lastLow = 0;
    end else begin
      bit doData, doIdle, doBrk;
      int len;
      if (bitTick && !txLine) lowCnt++;
      else if (txLine && lowCnt != 0) begin lastLow = lowCnt; lowCnt = 0; end
      if (mActive && bitTick) begin
        if (mTick == 15) begin
          mTick = 0; void'(mBits.pop_front());
          if (mBits.size() == 0) mActive = 0;
        end else mTick++;
      end
      doBrk = 0; doIdle = 0; doData = 0;
      if (txEnable && mEnPrev && !mActive) begin
        if (mBrk) doBrk = 1;
        else if (mIdle) doIdle = 1;
        else if (mHoldFull) doData = 1;
      end
      len = nineBit ? 11 : 10;
      if (doBrk || doIdle) begin
        for (int i = 0; i < len; i++) mBits.push_back(doIdle);
        mKind = doBrk ? 2 : 1;
      end else if (doData) begin
        mBits.push_back(0);
        for (int i = 0; i < len - 2; i++) mBits.push_back(mHold[i]);
        mBits.push_back(1);
        mKind = 0;
      end
      if (doBrk || doIdle || doData) begin mActive = 1; mTick = 0; end
      if (txEnable && !mEnPrev) mIdle = 1; else if (doIdle) mIdle = 0;
      if (sendBreak && !mBrkPrev) mBrk = 1; else if (doBrk) mBrk = sendBreak;
      if (dataWrite) begin mHoldFull = 1; mHold = dataIn; end
      else if (doData) mHoldFull = 0;
      mEnPrev = txEnable; mBrkPrev = sendBreak;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rstN && !finished) begin
    bit expLine;
    string tag;
    expLine = mActive ? mBits[0] : 1'b1;
    tag = !mActive ? "R11 line" : (mKind == 2) ? "R4 break" : (mKind == 1) ? "R8 idle" : "R2 data";
    check(txLine == expLine, tag, txLine, expLine);
    check(dataEmpty == !mHoldFull, "R3 dataEmpty", dataEmpty, !mHoldFull);
    check(txDone == (!mActive && !mHoldFull && !mIdle && !mBrk), "R10 txDone",
          txDone, (!mActive && !mHoldFull && !mIdle && !mBrk));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      check(0, "watchdog", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic writeData(input logic [8:0] d);
    @(negedge clk); dataIn = d; dataWrite = 1;
    @(negedge clk); dataWrite = 0;
  endtask
  task automatic waitDone();
    int k = 0;
    waitCycles(3);
    while (!txDone && k < 20000) begin @(negedge clk); k++; end
    waitCycles(2);
  endtask

  initial begin
    waitCycles(2);
    check(txLine == 1, "R1 line", txLine, 1);
    check(dataEmpty == 1, "R1 empty", dataEmpty, 1);
    check(txDone == 1, "R1 done", txDone, 1);
    rstN = 1;
    waitCycles(2);
    check(txLine == 1 && txDone == 1, "R1 after reset", txLine, 1);

    // R8 / R9: enable queues idle, data written at once waits behind it
    txEnable = 1;
    writeData(9'h0A5);
    waitCycles(4);
    check(txLine == 1 && dataEmpty == 0, "R9 data behind idle", txLine, 1);
    waitDone();

    // R2: 9-bit frames, second character buffered while first shifts
    nineBit = 1;
    writeData(9'h1C3);
    waitCycles(20);
    writeData(9'h055);
    check(dataEmpty == 0, "R3 buffered", dataEmpty, 0);
    waitDone();
    nineBit = 0;

    // R5 / R6: one-cycle break pulse during a data frame
    writeData(9'h03C);
    waitCycles(40);
    @(negedge clk); sendBreak = 1;
    @(negedge clk); sendBreak = 0;
    waitDone();
    check(lastLow == 160, "R5 R4 single short break", lastLow, 160);

    // R7: break held across a load, 9-bit, data queued behind it
    nineBit = 1;
    @(negedge clk); sendBreak = 1;
    waitCycles(100);
    writeData(9'h1FF);
    waitCycles(100);
    sendBreak = 0;
    waitDone();
    check(lastLow == 368, "R7 two long breaks then start bit", lastLow, 368);
    nineBit = 0;

    // R11: disabled transmitter holds buffered data
    txEnable = 0;
    writeData(9'h00F);
    waitCycles(400);
    check(txLine == 1, "R11 no load while off", txLine, 1);
    check(dataEmpty == 0, "R11 data kept", dataEmpty, 0);
    txEnable = 1;
    waitCycles(4);
    check(dataEmpty == 0, "R9 idle before data", dataEmpty, 0);
    waitDone();

    // R11 / R8: disable mid-frame, frame finishes, idle follows
    writeData(9'h0C6);
    waitCycles(50);
    txEnable = 0;
    waitCycles(10);
    txEnable = 1;
    waitDone();
    check(txDone == 1 && txLine == 1, "R10 quiet at end", txDone, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule